// File: doc/BRIEF.md
# Debug PC Sample Snapshot Register

This block gives an external debugger a consistent view of where a core is running. The core side sends a stream of sampled instruction addresses, each marked by a strobe. Each sample carries a 64-bit address, the security state, the exception level, a hypervisor-valid flag, a context ID and a VMID. A live register holds the newest sample. The debugger reads 32-bit words through a small read port with one-cycle latency.

Reading the low address word at offset 0x0A0 returns the low half of the live sample. The same read copies that sample into three readable snapshot words: the high address word at 0x0AC, the context word at 0x0A4 and the state/VMID word at 0x0A8. The debugger can therefore read the other halves later and still get values that belong together.

A software-lock input blocks the copy for memory-mapped accesses. A format-select input picks how the high word is laid out. Before the first sample arrives, the low word reads as all ones and the snapshot words become a fixed "undefined" pattern.

Top module: `pc_snap_reg`

## Requirements
- R1: `rd_ack` is 1 in exactly the cycle after a cycle with `rd_vld` = 1, and is 0 otherwise. `rd_data` is valid while `rd_ack` is 1.
- R2: A read (`rd_wr` = 0) at offset 0x0A0, made after at least one sample strobe since reset, returns bits [31:0] of the live sample as it stood before that cycle's strobe.
- R3: An unlocked read at 0x0A0 loads the snapshot words from that same live sample. The context word (offset 0x0A4) gets the context ID, zero-extended.
- R4: When `lock_on` = 1 and `rd_mmio` = 1, a read at 0x0A0 still returns data, but all three snapshot words keep their values. When `lock_on` = 1 and `rd_mmio` = 0, the snapshots update as usual.
- R5: If no sample has arrived since reset, a read at 0x0A0 returns 0xFFFFFFFF. Unless R4 suppresses it, the read also sets all three snapshot words to `UNK_WORD` (default all ones).
- R6: With `fmt_ext` = 0 at the time of the load, the high word (0x0AC) gets address bits [63:32] if the hypervisor-valid flag is 1, and 0 if it is 0.
- R7: With `fmt_ext` = 1 at the time of the load, the high word is laid out as follows: bit 31 is the security state (1 = non-secure), bits [30:29] are the exception level (0..3), bits [28:24] are 0, and bits [23:0] are address bits [55:32].
- R8: A snapshot word changes only on a read at 0x0A0. Reads at 0x0AC, 0x0A4 and 0x0A8 have no side effects and return the last loaded values. Sample strobes do not change the snapshots.
- R9: An access with `rd_wr` = 1 is acked with data 0 and changes no state.
- R10: After reset, all three snapshot words read as 0.
- R11: The state/VMID word (0x0A8) is laid out as follows: bit 31 is the security state, bit 30 is hypervisor-valid, bits [29:28] are the exception level, the low `VMID_W` bits are the VMID, and all other bits are 0. Any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Core sample strobe |
| smp_pc | input | 64 | Sampled instruction address |
| smp_ns | input | 1 | Security state of sample (1 = non-secure) |
| smp_el | input | 2 | Exception level of sample |
| smp_hv | input | 1 | Hypervisor-valid flag of sample |
| smp_ctx | input | 32 | Context ID of sample |
| smp_vmid | input | 16 | VMID of sample |
| fmt_ext | input | 1 | High-word format select (1 = extended) |
| lock_on | input | 1 | Software lock status |
| rd_vld | input | 1 | Access request |
| rd_wr | input | 1 | Access is a write (ignored) |
| rd_addr | input | 12 | Byte offset of access |
| rd_mmio | input | 1 | Access came through memory-mapped path |
| rd_ack | output | 1 | Response valid, one cycle after request |
| rd_data | output | 32 | Read data |

## Verification
Several rules are checked by assertions on every cycle: the one-cycle response timing, that the snapshots hold steady unless a low-word read loads them, that the lock keeps them frozen, that a loaded context word matches the live sample, and that the empty case produces the fixed pattern. Other behaviour is only visible through the bench's scenarios. These include the bit layout of the high word in both formats, the zeroed high word when hypervisor-valid is clear, and the lock having no effect on non-memory-mapped reads. They also include the ordering when a sample strobe and a low-word read land in the same cycle, and the reset values of the snapshot words.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    SEL_LO   = 3'd0,
    SEL_HI   = 3'd1,
    SEL_CTX  = 3'd2,
    SEL_VID  = 3'd3,
    SEL_NONE = 3'd4
  } word_sel_e;

  localparam int EL_W     = 2;
  localparam int HDR_BITS = 8;  // ns + el + five zero bits in extended high word
  localparam int VID_HDR  = 4;  // ns + hv + el in state/VMID word
endpackage

// File: rtl/pcs_live.sv
module pcs_live #(
  parameter int DW = 32,
  parameter int CW = 32,
  parameter int VW = 16,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [PW-1:0] smp_pc,
  input  logic          smp_ns,
  input  logic [1:0]    smp_el,
  input  logic          smp_hv,
  input  logic [CW-1:0] smp_ctx,
  input  logic [VW-1:0] smp_vmid,
  output logic [PW-1:0] live_pc,
  output logic          live_ns,
  output logic [1:0]    live_el,
  output logic          live_hv,
  output logic [CW-1:0] live_ctx,
  output logic [VW-1:0] live_vmid,
  output logic          live_have
);
  always_ff @(posedge clk) begin
    if (rst) begin
      live_pc   <= '0;
      live_ns   <= 1'b0;
      live_el   <= '0;
      live_hv   <= 1'b0;
      live_ctx  <= '0;
      live_vmid <= '0;
      live_have <= 1'b0;
    end else if (smp_valid) begin
      live_pc   <= smp_pc;
      live_ns   <= smp_ns;
      live_el   <= smp_el;
      live_hv   <= smp_hv;
      live_ctx  <= smp_ctx;
      live_vmid <= smp_vmid;
      live_have <= 1'b1;
    end
  end

  // R2: once a sample exists the live register stays populated until reset
  a_r2_have_sticky: assert property (@(posedge clk) disable iff (rst)
    live_have |=> live_have);
  // R8: live register follows the core strobe
  a_r8_live_follow: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> (live_pc == $past(smp_pc)) && live_have);
endmodule

// File: rtl/pcs_snap.sv
module pcs_snap
  import pcs_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 32,
  parameter int VW = 16,
  parameter logic [DW-1:0] UNK_WORD = '1,
  localparam int PW = 2 * DW,
  localparam int XW = DW - HDR_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          latch_en,
  input  logic          fmt_ext,
  input  logic [PW-1:0] live_pc,
  input  logic          live_ns,
  input  logic [1:0]    live_el,
  input  logic          live_hv,
  input  logic [CW-1:0] live_ctx,
  input  logic [VW-1:0] live_vmid,
  input  logic          live_have,
  output logic [DW-1:0] snap_hi,
  output logic [DW-1:0] snap_ctx,
  output logic [DW-1:0] snap_vid
);
  logic [DW-1:0] hi_fmt, ctx_fmt, vid_fmt;

  always_comb begin
    if (fmt_ext) begin
      hi_fmt = '0;
      hi_fmt[DW-1]          = live_ns;
      hi_fmt[DW-2 -: EL_W]  = live_el;
      hi_fmt[XW-1:0]        = live_pc[DW +: XW];
    end else begin
      hi_fmt = live_hv ? live_pc[PW-1:DW] : '0;
    end
  end

  always_comb begin
    ctx_fmt = '0;
    ctx_fmt[CW-1:0] = live_ctx;
  end

  always_comb begin
    vid_fmt = '0;
    vid_fmt[DW-1]         = live_ns;
    vid_fmt[DW-2]         = live_hv;
    vid_fmt[DW-3 -: EL_W] = live_el;
    vid_fmt[VW-1:0]       = live_vmid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_hi  <= '0;
      snap_ctx <= '0;
      snap_vid <= '0;
    end else if (latch_en) begin
      if (live_have) begin
        snap_hi  <= hi_fmt;
        snap_ctx <= ctx_fmt;
        snap_vid <= vid_fmt;
      end else begin
        snap_hi  <= UNK_WORD;
        snap_ctx <= UNK_WORD;
        snap_vid <= UNK_WORD;
      end
    end
  end

  a_r8_hold_unless_latch: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> $stable(snap_hi) && $stable(snap_ctx) && $stable(snap_vid));
  a_r3_ctx_from_live: assert property (@(posedge clk) disable iff (rst)
    (latch_en && live_have) |=> snap_ctx[CW-1:0] == $past(live_ctx));
  a_r5_unknown_fill: assert property (@(posedge clk) disable iff (rst)
    (latch_en && !live_have) |=> (snap_hi == UNK_WORD) && (snap_vid == UNK_WORD));
endmodule

// File: rtl/pcs_rdport.sv
module pcs_rdport
  import pcs_pkg::*;
#(
  parameter int DW = 32,
  parameter int OW = 12,
  parameter logic [OW-1:0] OFS_LO  = 12'h0A0,
  parameter logic [OW-1:0] OFS_CTX = 12'h0A4,
  parameter logic [OW-1:0] OFS_VID = 12'h0A8,
  parameter logic [OW-1:0] OFS_HI  = 12'h0AC,
  parameter logic [DW-1:0] EMPTY_WORD = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_vld,
  input  logic          rd_wr,
  input  logic [OW-1:0] rd_addr,
  input  logic          rd_mmio,
  input  logic          lock_on,
  input  logic [DW-1:0] live_lo,
  input  logic          live_have,
  input  logic [DW-1:0] snap_hi,
  input  logic [DW-1:0] snap_ctx,
  input  logic [DW-1:0] snap_vid,
  output logic          latch_en,
  output logic          rd_ack,
  output logic [DW-1:0] rd_data
);
  word_sel_e     sel;
  logic          is_rd;
  logic [DW-1:0] mux_word;

  always_comb begin
    if      (rd_addr == OFS_LO)  sel = SEL_LO;
    else if (rd_addr == OFS_HI)  sel = SEL_HI;
    else if (rd_addr == OFS_CTX) sel = SEL_CTX;
    else if (rd_addr == OFS_VID) sel = SEL_VID;
    else                         sel = SEL_NONE;
  end

  assign is_rd    = rd_vld && !rd_wr;
  assign latch_en = is_rd && (sel == SEL_LO) && !(lock_on && rd_mmio);

  always_comb begin
    case (sel)
      SEL_LO:  mux_word = live_have ? live_lo : EMPTY_WORD;
      SEL_HI:  mux_word = snap_hi;
      SEL_CTX: mux_word = snap_ctx;
      SEL_VID: mux_word = snap_vid;
      default: mux_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack  <= rd_vld;
      rd_data <= is_rd ? mux_word : '0;
    end
  end

  a_r1_ack_follows: assert property (@(posedge clk) disable iff (rst)
    rd_vld |=> rd_ack);
  a_r1_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
    !rd_vld |=> !rd_ack);
  a_r9_write_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && rd_wr) |=> rd_data == '0);
endmodule

// File: rtl/pc_snap_reg.sv
module pc_snap_reg #(
  parameter int DW = 32,
  parameter int CW = 32,
  parameter int VW = 16,
  parameter int OW = 12,
  parameter logic [OW-1:0] OFS_LO  = 12'h0A0,
  parameter logic [OW-1:0] OFS_CTX = 12'h0A4,
  parameter logic [OW-1:0] OFS_VID = 12'h0A8,
  parameter logic [OW-1:0] OFS_HI  = 12'h0AC,
  parameter logic [DW-1:0] EMPTY_WORD = '1,
  parameter logic [DW-1:0] UNK_WORD   = '1,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_valid,
  input  logic [PW-1:0] smp_pc,
  input  logic          smp_ns,
  input  logic [1:0]    smp_el,
  input  logic          smp_hv,
  input  logic [CW-1:0] smp_ctx,
  input  logic [VW-1:0] smp_vmid,
  input  logic          fmt_ext,
  input  logic          lock_on,
  input  logic          rd_vld,
  input  logic          rd_wr,
  input  logic [OW-1:0] rd_addr,
  input  logic          rd_mmio,
  output logic          rd_ack,
  output logic [DW-1:0] rd_data
);
  logic [PW-1:0] live_pc;
  logic          live_ns, live_hv, live_have;
  logic [1:0]    live_el;
  logic [CW-1:0] live_ctx;
  logic [VW-1:0] live_vmid;
  logic [DW-1:0] snap_hi, snap_ctx, snap_vid;
  logic          latch_en;

  pcs_live #(.DW(DW), .CW(CW), .VW(VW)) u_live (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_pc(smp_pc),
    .smp_ns(smp_ns), .smp_el(smp_el), .smp_hv(smp_hv), .smp_ctx(smp_ctx),
    .smp_vmid(smp_vmid), .live_pc(live_pc), .live_ns(live_ns),
    .live_el(live_el), .live_hv(live_hv), .live_ctx(live_ctx),
    .live_vmid(live_vmid), .live_have(live_have)
  );

  pcs_snap #(.DW(DW), .CW(CW), .VW(VW), .UNK_WORD(UNK_WORD)) u_snap (
    .clk(clk), .rst(rst), .latch_en(latch_en), .fmt_ext(fmt_ext),
    .live_pc(live_pc), .live_ns(live_ns), .live_el(live_el),
    .live_hv(live_hv), .live_ctx(live_ctx), .live_vmid(live_vmid),
    .live_have(live_have), .snap_hi(snap_hi), .snap_ctx(snap_ctx),
    .snap_vid(snap_vid)
  );

  pcs_rdport #(.DW(DW), .OW(OW), .OFS_LO(OFS_LO), .OFS_CTX(OFS_CTX),
    .OFS_VID(OFS_VID), .OFS_HI(OFS_HI), .EMPTY_WORD(EMPTY_WORD)) u_rd (
    .clk(clk), .rst(rst), .rd_vld(rd_vld), .rd_wr(rd_wr), .rd_addr(rd_addr),
    .rd_mmio(rd_mmio), .lock_on(lock_on), .live_lo(live_pc[DW-1:0]),
    .live_have(live_have), .snap_hi(snap_hi), .snap_ctx(snap_ctx),
    .snap_vid(snap_vid), .latch_en(latch_en), .rd_ack(rd_ack),
    .rd_data(rd_data)
  );

  // R4: locked memory-mapped low read leaves every snapshot untouched
  a_r4_lock_freeze: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && !rd_wr && rd_addr == OFS_LO && lock_on && rd_mmio)
      |=> $stable(snap_hi) && $stable(snap_ctx) && $stable(snap_vid));
  // R2: low read returns the live sample seen before the edge
  a_r2_lo_data: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && !rd_wr && rd_addr == OFS_LO && live_have)
      |=> rd_data == $past(live_pc[DW-1:0]));
  // R9: writes never load snapshots
  a_r9_write_no_latch: assert property (@(posedge clk) disable iff (rst)
    (rd_vld && rd_wr) |=> $stable(snap_hi) && $stable(snap_ctx));
endmodule

// File: tb/sim_pc_snap_reg.sv
module sim_pc_snap_reg;
  localparam int DW = 32, CW = 32, VW = 16, OW = 12;
  localparam logic [OW-1:0] A_LO = 12'h0A0, A_CTX = 12'h0A4,
                            A_VID = 12'h0A8, A_HI = 12'h0AC, A_BAD = 12'h0B0;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, smp_valid, smp_ns, smp_hv, fmt_ext, lock_on;
  logic        rd_vld, rd_wr, rd_mmio, rd_ack;
  logic [63:0] smp_pc;
  logic [1:0]  smp_el;
  logic [31:0] smp_ctx, rd_data;
  logic [15:0] smp_vmid;
  logic [11:0] rd_addr;

  pc_snap_reg u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_pc(smp_pc),
    .smp_ns(smp_ns), .smp_el(smp_el), .smp_hv(smp_hv), .smp_ctx(smp_ctx),
    .smp_vmid(smp_vmid), .fmt_ext(fmt_ext), .lock_on(lock_on),
    .rd_vld(rd_vld), .rd_wr(rd_wr), .rd_addr(rd_addr), .rd_mmio(rd_mmio),
    .rd_ack(rd_ack), .rd_data(rd_data)
  );

  int total = 0, bad = 0;
  bit done = 0;

  logic [63:0] m_pc;
  logic        m_ns, m_hv, m_have;
  logic [1:0]  m_el;
  logic [31:0] m_ctx, s_hi, s_ctx, s_vid;
  logic [15:0] m_vmid;

  function automatic logic [31:0] hi_of(logic [63:0] pc, logic ns, logic [1:0] el,
                                        logic hv, logic ext);
    if (ext) return {ns, el, 5'b0, pc[55:32]};
    return hv ? pc[63:32] : 32'h0;
  endfunction

  function automatic logic [31:0] vid_of(logic ns, logic hv, logic [1:0] el,
                                         logic [15:0] vm);
    return {ns, hv, el, 12'h0, vm};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access cycle; starts and ends at a falling edge
  task automatic step(bit smp, logic [63:0] pc, logic ns, logic [1:0] el, logic hv,
                      logic [31:0] ctx, logic [15:0] vm, bit rd, bit wr,
                      logic [11:0] a, bit lk, bit mm, bit fx, string tag);
    logic [31:0] exp;
    smp_valid = smp; smp_pc = pc; smp_ns = ns; smp_el = el; smp_hv = hv;
    smp_ctx = ctx; smp_vmid = vm; rd_vld = rd; rd_wr = wr; rd_addr = a;
    lock_on = lk; rd_mmio = mm; fmt_ext = fx;
    exp = 32'h0;
    if (rd && !wr) begin
      case (a)
        A_LO: begin
          exp = m_have ? m_pc[31:0] : ONES;
          if (!(lk && mm)) begin
            if (m_have) begin
              s_hi = hi_of(m_pc, m_ns, m_el, m_hv, fx);
              s_ctx = m_ctx;
              s_vid = vid_of(m_ns, m_hv, m_el, m_vmid);
            end else begin
              s_hi = ONES; s_ctx = ONES; s_vid = ONES;
            end
          end
        end
        A_HI:    exp = s_hi;
        A_CTX:   exp = s_ctx;
        A_VID:   exp = s_vid;
        default: exp = 32'h0;
      endcase
    end
    if (smp) begin
      m_pc = pc; m_ns = ns; m_el = el; m_hv = hv; m_ctx = ctx; m_vmid = vm;
      m_have = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    if (rd) begin
      chk({tag, " R1 ack"}, {31'b0, rd_ack}, 32'h1);
      chk(tag, rd_data, exp);
    end else begin
      chk("R1 idle ack", {31'b0, rd_ack}, 32'h0);
    end
    smp_valid = 1'b0; rd_vld = 1'b0; rd_wr = 1'b0;
  endtask

  task automatic rd_only(logic [11:0] a, bit lk, bit mm, bit fx, string tag);
    step(0, 64'h0, 0, 2'd0, 0, 32'h0, 16'h0, 1, 0, a, lk, mm, fx, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst = 1; smp_valid = 0; smp_pc = 0; smp_ns = 0; smp_el = 0; smp_hv = 0;
    smp_ctx = 0; smp_vmid = 0; fmt_ext = 0; lock_on = 0; rd_vld = 0;
    rd_wr = 0; rd_addr = 0; rd_mmio = 0;
    m_pc = 0; m_ns = 0; m_hv = 0; m_el = 0; m_ctx = 0; m_vmid = 0; m_have = 0;
    s_hi = 0; s_ctx = 0; s_vid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1 reset ack", {31'b0, rd_ack}, 32'h0);

    rd_only(A_HI,  0, 0, 0, "R10 hi reset");
    rd_only(A_CTX, 0, 0, 0, "R10 ctx reset");
    rd_only(A_VID, 0, 0, 0, "R10 vid reset");
    rd_only(A_LO,  1, 1, 0, "R5 empty locked lo");
    rd_only(A_HI,  0, 0, 0, "R4 hi frozen by lock");
    rd_only(A_LO,  0, 0, 0, "R5 empty lo");
    rd_only(A_HI,  0, 0, 0, "R5 hi unknown");
    rd_only(A_VID, 0, 0, 0, "R5 vid unknown");

    step(1, 64'h1111_2222_3333_4444, 1, 2'd1, 0, 32'hC0DE_0001, 16'h00A5,
         0, 0, A_LO, 0, 0, 0, "R2 sample");
    rd_only(A_LO,  0, 0, 0, "R2 lo data");
    rd_only(A_HI,  0, 0, 0, "R6 hv zero");
    rd_only(A_CTX, 0, 0, 0, "R3 ctx");
    rd_only(A_VID, 0, 0, 0, "R11 vid layout");

    step(1, 64'h89AB_CDEF_0123_4567, 0, 2'd2, 1, 32'h0000_7777, 16'hBEEF,
         0, 0, A_LO, 0, 0, 0, "R6 sample");
    rd_only(A_LO, 0, 0, 0, "R2 lo data b");
    rd_only(A_HI, 0, 0, 0, "R6 hi word");
    chk("R6 hi literal", rd_data, 32'h89AB_CDEF);

    rd_only(A_LO, 0, 0, 1, "R7 latch ext");
    rd_only(A_HI, 0, 0, 0, "R7 hi ext");
    chk("R7 hi ext literal", rd_data, {1'b0, 2'd2, 5'b0, 24'hAB_CDEF});

    step(1, 64'hFFEE_DDCC_BBAA_9988, 1, 2'd3, 1, 32'h1234_5678, 16'h0042,
         0, 0, A_LO, 0, 0, 0, "R4 sample c");
    rd_only(A_LO, 1, 0, 0, "R4 lock non-mmio lo");
    rd_only(A_CTX, 0, 0, 0, "R4 non-mmio updates");
    step(1, 64'h0102_0304_0506_0708, 0, 2'd0, 1, 32'h9999_0000, 16'h0007,
         0, 0, A_LO, 0, 0, 0, "R4 sample d");
    rd_only(A_LO, 1, 1, 0, "R4 locked lo data");
    rd_only(A_HI, 0, 0, 0, "R4 locked hi kept");
    rd_only(A_CTX, 0, 0, 0, "R4 locked ctx kept");

    step(1, 64'hAAAA_BBBB_CCCC_DDDD, 1, 2'd1, 1, 32'h5555_AAAA, 16'h1111,
         1, 0, A_LO, 0, 0, 0, "R2 sample with lo read same cycle");
    step(0, 64'h0, 0, 2'd0, 0, 32'h0, 16'h0, 1, 1, A_LO, 0, 0, 0, "R9 write zero");
    rd_only(A_CTX, 0, 0, 0, "R9 write no latch");
    step(1, 64'h7, 0, 2'd0, 0, 32'h0, 16'h0, 0, 0, A_LO, 0, 0, 0, "R8 sample");
    rd_only(A_HI, 0, 0, 0, "R8 hi unchanged by sample");
    rd_only(A_HI, 0, 0, 0, "R8 hi repeat");
    rd_only(A_BAD, 0, 0, 0, "R11 unmapped");

    for (int i = 0; i < 3000; i++) begin
      bit smp, rd, wr, lk, mm, fx;
      logic [11:0] a;
      string tag;
      int pick;
      smp = $urandom_range(0, 1);
      rd = ($urandom_range(0, 9) < 7);
      wr = ($urandom_range(0, 9) == 0);
      lk = ($urandom_range(0, 3) == 0);
      mm = $urandom_range(0, 1);
      fx = $urandom_range(0, 1);
      pick = $urandom_range(0, 5);
      case (pick)
        0, 1: begin a = A_LO;  tag = "R2 rand lo"; end
        2:    begin a = A_HI;  tag = "R8 rand hi"; end
        3:    begin a = A_CTX; tag = "R3 rand ctx"; end
        4:    begin a = A_VID; tag = "R11 rand vid"; end
        default: begin a = A_BAD; tag = "R11 rand unmapped"; end
      endcase
      if (wr) tag = "R9 rand write";
      step(smp, {$urandom, $urandom}, 1'($urandom), 2'($urandom), 1'($urandom),
           $urandom, 16'($urandom), rd, wr, a, lk, mm, fx, tag);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule